// File: doc/BRIEF.md
# Keyboard Scancode Translator and Responder

This block sits between a keyboard event source and a serial receive channel. It takes host-style scancode bytes, one per strobe, and rewrites each one into a different keyboard code set. Each result goes into a byte queue that the serial channel drains through a pop interface. It also acts as the keyboard's command decoder. Command bytes written by the host can flush the queue and replace its contents with a short identification or layout reply. One command arms a skip of the command byte that follows it.

The translation keeps three kinds of state. The first is an extended flag, armed by a prefix byte, which selects a second code map for the next accepted code. The other two are a pair of two-bit lock filters, one for Caps Lock and one for Num Lock. Each filter suppresses the duplicate press/release pairs that a toggling lock key produces. The release bit (bit 7) always passes through to the translated byte.

Top module: `kbd_xlate_top`

## Requirements
- R1: A scancode b that is not special is queued as `((b[6:0]*5+3) mod 128) | (b & 0x80)` in the cycle its strobe is sampled. The special codes are 0xE0, 0x3A, 0xBA, 0x45 and 0xC5.
- R2: Scancode 0xE0 queues nothing and arms the extended flag. The next queued code c is mapped with the extended map: `c[6:0]+0x1A` if c[6:0] is in 0x47..0x53, else 0x00, ORed with `c & 0x80`. Queuing that code clears the flag.
- R3: Caps Lock has a 2-bit state that reset clears. Press 0x3A flips bit 0 and is dropped if the result is 2. Release 0xBA flips bit 1 and is dropped if the result is 3. Codes that are not dropped are translated as in R1 or R2. A dropped code leaves the extended flag as it was.
- R4: Num Lock (press 0x45, release 0xC5) has its own state that follows the same rules as R3 and does not interact with Caps Lock.
- R5: Command 0x01 empties the queue, then leaves exactly 0xFF, 0x04, 0x7F in it, in that order.
- R6: Commands 0x07 and 0x0F empty the queue, then leave exactly 0xFE, 0x00 in it.
- R7: Command 0x0E arms a skip. The next command byte accepted has no effect and clears the skip.
- R8: Any other command byte leaves the queue unchanged.
- R9: While `kbd_off` is high, command bytes have no effect, and the skip flag from R7 is neither set nor cleared. Scancodes are still translated.
- R10: The queue is first-in first-out and holds QUEUE_DEPTH (256) bytes. A byte that arrives while the queue is full is dropped. A pop while the queue is empty does nothing. `q_nonempty` is high whenever the queue holds at least one byte, and `q_data` shows the oldest byte.
- R11: Reset empties the queue and clears the extended flag, both lock states and the skip flag.
- R12: If a command reply (R5, R6) and a scancode arrive in the same cycle, the reply alone fills the queue. The lock and prefix state still update from the scancode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| kbd_off | input | 1 | Command decoding disabled when high |
| sc_valid | input | 1 | Scancode strobe |
| sc_code | input | 8 | Scancode byte |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 8 | Command byte from the host |
| q_pop | input | 1 | Remove the oldest queued byte |
| q_data | output | 8 | Oldest queued byte |
| q_nonempty | output | 1 | Queue holds at least one byte |

## Verification
The properties take some things as given. Reset is held high from time zero. QUEUE_DEPTH is a power of two and at least three. Strobes and `kbd_off` are ordinary synchronous levels that are sampled only at rising edges. The lock-filter and skip properties also rely on the scancode and command strobes being independent, so any mix of them is legal. The bench drives every input on the falling edge and raises one strobe per task. The only same-cycle scancode and command pair is the one in the R12 test, so every other expected queue content follows from one event at a time.

// File: rtl/kbx_pkg.sv
package kbx_pkg;

    localparam int BYTE_W    = 8;
    localparam int RESP_MAX  = 3;
    localparam int NUM_LOCKS = 2;

    // prefix byte that selects the extended map for one code
    localparam logic [BYTE_W-1:0] PREFIX_CODE = 8'hE0;

    // lock key codes without the release bit: index 0 caps, index 1 num
    localparam logic [NUM_LOCKS-1:0][6:0] LOCK_CODES = {7'h45, 7'h3A};

    // plain map: multiply-add modulo 128 (odd multiplier keeps it bijective)
    localparam int MAP_MUL = 5;
    localparam int MAP_ADD = 3;

    // extended map: a window of codes shifted up, everything else to zero
    localparam logic [6:0] EXT_LO  = 7'h47;
    localparam logic [6:0] EXT_HI  = 7'h53;
    localparam logic [6:0] EXT_OFS = 7'h1A;

    // command byte values
    localparam logic [BYTE_W-1:0] CMD_IDENT   = 8'h01;
    localparam logic [BYTE_W-1:0] CMD_LAYOUT0 = 8'h07;
    localparam logic [BYTE_W-1:0] CMD_LEDS    = 8'h0E;
    localparam logic [BYTE_W-1:0] CMD_LAYOUT1 = 8'h0F;

    // scripted replies, element 0 leaves the queue first
    localparam logic [RESP_MAX-1:0][BYTE_W-1:0] IDENT_REPLY  = {8'h7F, 8'h04, 8'hFF};
    localparam logic [1:0]                      IDENT_LEN    = 2'd3;
    localparam logic [RESP_MAX-1:0][BYTE_W-1:0] LAYOUT_REPLY = {8'h00, 8'h00, 8'hFE};
    localparam logic [1:0]                      LAYOUT_LEN   = 2'd2;

    typedef logic [1:0] lock_st_t;  // bit0 press parity, bit1 release parity

    typedef enum logic [1:0] {
        CK_OTHER,
        CK_IDENT,
        CK_LAYOUT,
        CK_LEDS
    } cmd_kind_e;

    typedef struct packed {
        logic              en;
        logic [BYTE_W-1:0] data;
    } kbx_push_t;

    typedef struct packed {
        logic                               en;
        logic [1:0]                         len;
        logic [RESP_MAX-1:0][BYTE_W-1:0]    bytes;
    } kbx_load_t;

    function automatic logic [6:0] map_plain(input logic [6:0] c);
        logic [9:0] t;
        t = 10'(c) * 10'(MAP_MUL) + 10'(MAP_ADD);
        return t[6:0];
    endfunction

    function automatic logic [6:0] map_ext(input logic [6:0] c);
        if (c >= EXT_LO && c <= EXT_HI)
            return c + EXT_OFS;
        return 7'h00;
    endfunction

    function automatic cmd_kind_e decode_cmd(input logic [BYTE_W-1:0] b);
        if (b == CMD_IDENT)                        return CK_IDENT;
        if (b == CMD_LAYOUT0 || b == CMD_LAYOUT1)  return CK_LAYOUT;
        if (b == CMD_LEDS)                         return CK_LEDS;
        return CK_OTHER;
    endfunction

endpackage

// File: rtl/kbx_code_map.sv
module kbx_code_map
    import kbx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_code,
    output kbx_push_t         push_o
);

    logic                 ext_q;
    logic [NUM_LOCKS-1:0] drop_v;
    logic                 is_prefix;
    logic                 keep;
    logic [6:0]           body;

    assign is_prefix = in_valid && (in_code == PREFIX_CODE);

    generate
        for (genvar g = 0; g < NUM_LOCKS; g++) begin : g_lock
            lock_st_t st_q;
            lock_st_t st_nx;
            logic     hit_press;
            logic     hit_rel;
            logic     drop_g;

            always_comb begin
                hit_press = in_valid && (in_code == {1'b0, LOCK_CODES[g]});
                hit_rel   = in_valid && (in_code == {1'b1, LOCK_CODES[g]});
                st_nx     = st_q;
                if (hit_press)
                    st_nx = st_q ^ 2'b01;
                else if (hit_rel)
                    st_nx = st_q ^ 2'b10;
                drop_g = (hit_press && st_nx == 2'd2) || (hit_rel && st_nx == 2'd3);
            end

            always_ff @(posedge clk) begin
                if (rst) st_q <= '0;
                else     st_q <= st_nx;
            end

            assign drop_v[g] = drop_g;

            // R3 (g=0) and R4 (g=1): a second press after a full cycle is swallowed
            p_lock_press_drop_r3: assert property (@(posedge clk) disable iff (rst)
                (hit_press && st_q == 2'b11) |-> !push_o.en);
            // R3/R4: the first release after a press is swallowed
            p_lock_rel_drop_r4: assert property (@(posedge clk) disable iff (rst)
                (hit_rel && st_q == 2'b01) |-> !push_o.en);
        end
    endgenerate

    always_comb begin
        keep        = in_valid && !is_prefix && !(|drop_v);
        body        = ext_q ? map_ext(in_code[6:0]) : map_plain(in_code[6:0]);
        push_o.en   = keep;
        push_o.data = {in_code[7], body};
    end

    always_ff @(posedge clk) begin
        if (rst)            ext_q <= 1'b0;
        else if (is_prefix) ext_q <= 1'b1;
        else if (keep)      ext_q <= 1'b0;
    end

    // R2: the prefix arms the extended flag for the following cycle
    p_prefix_arms_r2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_code == PREFIX_CODE) |=> ext_q);

    // R2: a queued code consumes the extended flag
    p_ext_consumed_r2: assert property (@(posedge clk) disable iff (rst)
        (push_o.en && ext_q) |=> !ext_q);

endmodule

// File: rtl/kbx_cmd_resp.sv
module kbx_cmd_resp
    import kbx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              off,
    input  logic              cmd_valid,
    input  logic [BYTE_W-1:0] cmd_byte,
    output kbx_load_t         load_o
);

    logic      skip_q;
    logic      skip_nx;
    logic      take;
    cmd_kind_e kind;

    always_comb begin
        take    = cmd_valid && !off;
        kind    = decode_cmd(cmd_byte);
        skip_nx = skip_q;
        load_o  = '0;
        if (take) begin
            if (skip_q) begin
                skip_nx = 1'b0;
            end else begin
                unique case (kind)
                    CK_IDENT: begin
                        load_o.en    = 1'b1;
                        load_o.len   = IDENT_LEN;
                        load_o.bytes = IDENT_REPLY;
                    end
                    CK_LAYOUT: begin
                        load_o.en    = 1'b1;
                        load_o.len   = LAYOUT_LEN;
                        load_o.bytes = LAYOUT_REPLY;
                    end
                    CK_LEDS:  skip_nx = 1'b1;
                    default:  ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) skip_q <= 1'b0;
        else     skip_q <= skip_nx;
    end

    // R9: a disabled command path never rewrites the queue
    p_off_no_load_r9: assert property (@(posedge clk) disable iff (rst)
        off |-> !load_o.en);

    // R9: the skip flag is frozen while disabled
    p_off_skip_frozen_r9: assert property (@(posedge clk) disable iff (rst)
        off |=> $stable(skip_q));

    // R7: the byte after an LED command is eaten and disarms the skip
    p_skip_eats_r7: assert property (@(posedge clk) disable iff (rst)
        (skip_q && cmd_valid && !off) |=> !skip_q);

endmodule

// File: rtl/kbx_byte_queue.sv
module kbx_byte_queue
    import kbx_pkg::*;
#(
    parameter int DEPTH = 256
) (
    input  logic              clk,
    input  logic              rst,
    input  kbx_push_t         push_i,
    input  kbx_load_t         load_i,
    input  logic              pop_i,
    output logic [BYTE_W-1:0] data_o,
    output logic              nonempty_o
);

    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    logic [BYTE_W-1:0] mem_q [DEPTH];
    logic [AW-1:0]     rd_q;
    logic [AW-1:0]     wr_q;
    logic [CW-1:0]     cnt_q;
    logic              push_ok;
    logic              pop_ok;

    assign push_ok = push_i.en && (cnt_q != FULL_CNT);
    assign pop_ok  = pop_i && (cnt_q != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q  <= '0;
            wr_q  <= '0;
            cnt_q <= '0;
        end else if (load_i.en) begin
            rd_q  <= '0;
            wr_q  <= AW'(load_i.len);
            cnt_q <= CW'(load_i.len);
        end else begin
            if (push_ok) wr_q <= wr_q + 1'b1;
            if (pop_ok)  rd_q <= rd_q + 1'b1;
            cnt_q <= cnt_q + CW'(push_ok) - CW'(pop_ok);
        end
    end

    always_ff @(posedge clk) begin
        if (load_i.en) begin
            for (int i = 0; i < RESP_MAX; i++) begin
                if (i < int'(load_i.len))
                    mem_q[AW'(i)] <= load_i.bytes[i];
            end
        end else if (push_ok) begin
            mem_q[wr_q] <= push_i.data;
        end
    end

    assign data_o     = mem_q[rd_q];
    assign nonempty_o = (cnt_q != '0);

    // R10: occupancy never exceeds the depth
    p_no_overflow_r10: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= FULL_CNT);

    // R10: a push into a full queue is dropped
    p_full_drop_r10: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == FULL_CNT && push_i.en && !pop_i && !load_i.en)
        |=> (cnt_q == FULL_CNT) && $stable(wr_q));

    // R10: a pop of an empty queue changes nothing
    p_pop_empty_r10: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == '0 && pop_i && !push_i.en && !load_i.en) |=> (cnt_q == '0) && $stable(rd_q));

    // R5/R6/R12: a reply load replaces the whole content
    p_load_flush_r5: assert property (@(posedge clk) disable iff (rst)
        load_i.en |=> (cnt_q == CW'($past(load_i.len))) && (rd_q == '0));

endmodule

// File: rtl/kbd_xlate_top.sv
module kbd_xlate_top
    import kbx_pkg::*;
#(
    parameter int QUEUE_DEPTH = 256
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       kbd_off,
    input  logic       sc_valid,
    input  logic [7:0] sc_code,
    input  logic       cmd_valid,
    input  logic [7:0] cmd_code,
    input  logic       q_pop,
    output logic [7:0] q_data,
    output logic       q_nonempty
);

    kbx_push_t push_w;
    kbx_load_t load_w;

    kbx_code_map u_map (
        .clk      (clk),
        .rst      (rst),
        .in_valid (sc_valid),
        .in_code  (sc_code),
        .push_o   (push_w)
    );

    kbx_cmd_resp u_cmd (
        .clk       (clk),
        .rst       (rst),
        .off       (kbd_off),
        .cmd_valid (cmd_valid),
        .cmd_byte  (cmd_code),
        .load_o    (load_w)
    );

    kbx_byte_queue #(
        .DEPTH (QUEUE_DEPTH)
    ) u_queue (
        .clk        (clk),
        .rst        (rst),
        .push_i     (push_w),
        .load_i     (load_w),
        .pop_i      (q_pop),
        .data_o     (q_data),
        .nonempty_o (q_nonempty)
    );

    // R12: a reply and a scancode together leave the queue holding the reply only
    p_reply_wins_r12: assert property (@(posedge clk) disable iff (rst)
        (load_w.en && push_w.en) |=> q_nonempty && (q_data == $past(load_w.bytes[0])));

endmodule

// File: tb/kbd_xlate_top_tb_top.sv
module kbd_xlate_top_tb_top;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       kbd_off = 1'b0;
    logic       sc_valid = 1'b0;
    logic [7:0] sc_code = 8'h00;
    logic       cmd_valid = 1'b0;
    logic [7:0] cmd_code = 8'h00;
    logic       q_pop = 1'b0;
    logic [7:0] q_data;
    logic       q_nonempty;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    kbd_xlate_top dut_i (
        .clk        (clk),
        .rst        (rst),
        .kbd_off    (kbd_off),
        .sc_valid   (sc_valid),
        .sc_code    (sc_code),
        .cmd_valid  (cmd_valid),
        .cmd_code   (cmd_code),
        .q_pop      (q_pop),
        .q_data     (q_data),
        .q_nonempty (q_nonempty)
    );

    function automatic logic [7:0] exp_plain(input logic [7:0] b);
        int v;
        v = ((int'(b) % 128) * 5 + 3) % 128;
        return 8'(v) | (b & 8'h80);
    endfunction

    function automatic logic [7:0] exp_ext(input logic [7:0] b);
        int lo;
        int v;
        lo = int'(b) % 128;
        v  = (lo >= 71 && lo <= 83) ? lo + 26 : 0;
        return 8'(v) | (b & 8'h80);
    endfunction

    function automatic bit is_special(input logic [7:0] b);
        return b == 8'hE0 || b == 8'h3A || b == 8'hBA || b == 8'h45 || b == 8'hC5;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    // all tasks start and end at a falling edge
    task automatic send_sc(input logic [7:0] b);
        sc_valid = 1'b1; sc_code = b;
        @(negedge clk);
        sc_valid = 1'b0;
    endtask

    task automatic send_cmd(input logic [7:0] b);
        cmd_valid = 1'b1; cmd_code = b;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic pop_chk(input logic [7:0] exp, input string req);
        chk(q_nonempty == 1'b1, {req, " nonempty"}, {7'b0, q_nonempty}, 8'h01);
        chk(q_data == exp, req, q_data, exp);
        q_pop = 1'b1;
        @(negedge clk);
        q_pop = 1'b0;
    endtask

    task automatic empty_chk(input string req);
        chk(q_nonempty == 1'b0, {req, " empty"}, {7'b0, q_nonempty}, 8'h00);
    endtask

    task automatic report;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        empty_chk("R11 reset");

        // R1: every non-special code, one at a time
        for (int b = 0; b < 256; b++) begin
            if (!is_special(8'(b))) begin
                send_sc(8'(b));
                pop_chk(exp_plain(8'(b)), "R1 plain map");
            end
        end

        // R2: every non-special code behind the prefix
        for (int b = 0; b < 256; b++) begin
            if (!is_special(8'(b))) begin
                send_sc(8'hE0);
                empty_chk("R2 prefix silent");
                send_sc(8'(b));
                pop_chk(exp_ext(8'(b)), "R2 ext map");
            end
        end
        send_sc(8'h10);
        pop_chk(exp_plain(8'h10), "R2 flag cleared");

        // R3: caps lock filter
        send_sc(8'h3A); pop_chk(exp_plain(8'h3A), "R3 first press");
        send_sc(8'hBA); empty_chk("R3 first release dropped");
        send_sc(8'h3A); empty_chk("R3 second press dropped");
        send_sc(8'hBA); pop_chk(exp_plain(8'hBA), "R3 second release");
        send_sc(8'h3A);
        send_sc(8'hE0);
        send_sc(8'hBA);
        send_sc(8'h50);
        pop_chk(exp_plain(8'h3A), "R3 press");
        pop_chk(exp_ext(8'h50), "R3 prefix kept over drop");
        empty_chk("R3 release dropped");
        send_sc(8'h3A); send_sc(8'hBA);
        pop_chk(exp_plain(8'hBA), "R3 restore");
        empty_chk("R3 restore");

        // R4: num lock independent of caps lock
        send_sc(8'h3A); send_sc(8'h45); send_sc(8'hBA); send_sc(8'hC5);
        pop_chk(exp_plain(8'h3A), "R4 caps press");
        pop_chk(exp_plain(8'h45), "R4 num press");
        empty_chk("R4 releases dropped");
        send_sc(8'h3A); send_sc(8'h45); send_sc(8'hBA); send_sc(8'hC5);
        pop_chk(exp_plain(8'hBA), "R4 caps release");
        pop_chk(exp_plain(8'hC5), "R4 num release");
        empty_chk("R4 end");

        // R10: fill past depth, then drain
        for (int i = 0; i < 260; i++) send_sc(8'(i % 32));
        for (int i = 0; i < 256; i++) pop_chk(exp_plain(8'(i % 32)), "R10 fifo order");
        empty_chk("R10 overflow dropped");
        q_pop = 1'b1; @(negedge clk); q_pop = 1'b0;
        empty_chk("R10 pop empty");
        send_sc(8'h21);
        pop_chk(exp_plain(8'h21), "R10 after empty pop");
        empty_chk("R10 single");

        // R5: identification reply replaces content
        send_sc(8'h11); send_sc(8'h12);
        send_cmd(8'h01);
        pop_chk(8'hFF, "R5 byte0");
        pop_chk(8'h04, "R5 byte1");
        pop_chk(8'h7F, "R5 byte2");
        empty_chk("R5 end");

        // R6: both layout codes
        send_sc(8'h13);
        send_cmd(8'h07);
        pop_chk(8'hFE, "R6 07 byte0");
        pop_chk(8'h00, "R6 07 byte1");
        empty_chk("R6 07 end");
        send_cmd(8'h0F);
        pop_chk(8'hFE, "R6 0F byte0");
        pop_chk(8'h00, "R6 0F byte1");
        empty_chk("R6 0F end");

        // R7: LED command eats next byte
        send_sc(8'h14);
        send_cmd(8'h0E);
        send_cmd(8'h01);
        pop_chk(exp_plain(8'h14), "R7 skipped byte");
        empty_chk("R7 skipped byte");
        send_cmd(8'h01);
        pop_chk(8'hFF, "R7 skip cleared");
        pop_chk(8'h04, "R7 skip cleared");
        pop_chk(8'h7F, "R7 skip cleared");

        // R8: all other command values are inert
        send_sc(8'h15);
        for (int c = 0; c < 256; c++) begin
            if (c != 1 && c != 7 && c != 14 && c != 15) send_cmd(8'(c));
        end
        pop_chk(exp_plain(8'h15), "R8 other commands");
        empty_chk("R8 other commands");

        // R9: disabled command path
        kbd_off = 1'b1;
        send_sc(8'h16);
        send_cmd(8'h01);
        send_cmd(8'h0E);
        pop_chk(exp_plain(8'h16), "R9 off ignores command");
        empty_chk("R9 off ignores command");
        kbd_off = 1'b0;
        send_cmd(8'h0F);
        pop_chk(8'hFE, "R9 skip untouched");
        pop_chk(8'h00, "R9 skip untouched");

        // R12: reply and scancode in one cycle
        send_sc(8'h17);
        sc_valid = 1'b1; sc_code = 8'h18; cmd_valid = 1'b1; cmd_code = 8'h07;
        @(negedge clk);
        sc_valid = 1'b0; cmd_valid = 1'b0;
        pop_chk(8'hFE, "R12 reply wins");
        pop_chk(8'h00, "R12 reply wins");
        empty_chk("R12 scancode discarded");

        // R11: reset mid-stream
        send_sc(8'h19);
        send_sc(8'h3A);
        send_sc(8'hE0);
        rst = 1'b1; @(negedge clk); rst = 1'b0;
        empty_chk("R11 queue cleared");
        send_sc(8'hBA);
        pop_chk(exp_plain(8'hBA), "R11 lock and prefix cleared");
        empty_chk("R11 end");

        report();
        $finish;
    end

endmodule